// File: doc/BRIEF.md
# JTAG Pin-Sharing Port Controller

This block sits between a general-purpose I/O port and a JTAG programming channel. It decides, cycle by cycle, whether six pins of the port belong to the serial test channel or stay with the ordinary I/O logic. Pin ownership comes from three enable sources that are simply ORed. The first is a nonvolatile configuration bit. The second is a run-time enable bit that the microcontroller writes through a small register interface. The third is a product-term input from programmable logic.

Once the pins are owned, the mode-select, clock and data-in pins act as inputs and are passed to the TAP logic. The data-out pin is only driven after the TAP logic reports a serial enabling command, which arrives as a one-cycle pulse. A qualifier on that pulse also decides whether the status and error pins leave general I/O and carry TAP status. How reset affects the channel depends on the source of the enable. A channel held by the nonvolatile bit keeps running through reset. A channel held only by the register or the product term is blocked while reset is asserted.

Top module: `jtag_port_share`

## Requirements
- R1: `jtag_owned` is 1 whenever at least one of `nv_cfg_jtag`, the run-time enable bit or `pt_select` is 1, and 0 otherwise. `nv_cfg_jtag`=1 is the erased (blank) default and enables the pins.
- R2: A write with `bus_we`=1 at address 0xC7 loads the enable bit from `bus_wdata[0]` at the next clock edge. A write to any other address leaves the bit unchanged. While `bus_addr`=0xC7, `bus_rdata` shows the bit in bit 0 with all other bits 0. At any other address `bus_rdata` is 0.
- R3: Synchronous active-low reset (`rst_n`=0 at a clock edge) clears the run-time enable bit.
- R4: While `jtag_owned`=1, pins 0 (mode select), 1 (clock) and 5 (data in) have `pad_oe`=0 and `pad_out`=0. Pin 6 (data out) has `pad_oe`=0 until an enabling command has been accepted. `gpio_in` reads 0 on every pin held by the channel.
- R5: When `cmd_pulse`=1 at an edge while `tap_enable`=1, pin 6 is driven from the next cycle onward: `pad_oe[6]`=1 and `pad_out[6]`=`tap_tdo`.
- R6: The accepted command loads the extension flag from `cmd_ext`. While that flag is set and `jtag_owned`=1, pin 3 drives `tap_tstat` and pin 4 drives `tap_terr` with `pad_oe`=1. Otherwise pins 3 and 4 follow the GPIO side.
- R7: While `jtag_owned`=0, every pin has `pad_out`=`gpio_out`, `pad_oe`=`gpio_oe` and `gpio_in`=`pad_in`. An edge with `jtag_owned`=0 clears both the data-out flag and the extension flag.
- R8: While `nv_cfg_jtag`=1, reset affects neither `tap_enable` nor the data-out and extension flags.
- R9: While `nv_cfg_jtag`=0 and `rst_n`=0, `tap_enable` is 0, and an edge in that state clears the data-out and extension flags.
- R10: `tap_enable` is 1 when `jtag_owned`=1 and either `nv_cfg_jtag`=1 or `rst_n`=1. While `tap_enable`=1, `tap_tms`, `tap_tck` and `tap_tdi` follow `pad_in[0]`, `pad_in[1]` and `pad_in[5]`. While `tap_enable`=0 they are held at 1, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_cfg_jtag | input | 1 | Nonvolatile pin-dedication bit (1 = erased default, enabled) |
| pt_select | input | 1 | Product-term enable from programmable logic |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| cmd_pulse | input | 1 | One-cycle enabling-command indication from the TAP |
| cmd_ext | input | 1 | Qualifier on cmd_pulse: also enable status and error pins |
| tap_tdo | input | 1 | Serial data out from the TAP |
| tap_tstat | input | 1 | Status from the TAP |
| tap_terr | input | 1 | Error flag from the TAP |
| tap_tms | output | 1 | Mode select to the TAP |
| tap_tck | output | 1 | Test clock to the TAP |
| tap_tdi | output | 1 | Serial data in to the TAP |
| tap_enable | output | 1 | Channel may run (ownership, reset rule applied) |
| jtag_owned | output | 1 | Pins are held by the channel |
| gpio_out | input | PORT_W | GPIO output values |
| gpio_oe | input | PORT_W | GPIO output enables |
| gpio_in | output | PORT_W | Pad values returned to GPIO |
| pad_in | input | PORT_W | Pad input values |
| pad_out | output | PORT_W | Pad output values |
| pad_oe | output | PORT_W | Pad output enables |

## Verification
The assertions rely on `cmd_pulse` being high for one cycle at a time, as the TAP logic produces it. They also rely on the port being at least seven bits wide, so that the fixed pin positions exist. The stimulus forces `cmd_pulse` low in the cycle after every pulse. It keeps `nv_cfg_jtag` low through the first reset so that both flags start cleared, because the flags are not reset while the nonvolatile bit is set. After that, random traffic mixes all three enable sources with register writes to the enable address and to other addresses, together with short reset pulses.

// File: rtl/jps_pkg.sv
`timescale 1ns/1ps
// Package: shared pin roles and fixed pin positions for the JTAG port share.
// Assumes the port is at least seven bits wide.
package jps_pkg;

    // Pin positions (decoded by the pad ring, so they are fixed)
    localparam int PIN_TMS  = 0;
    localparam int PIN_TCK  = 1;
    localparam int PIN_STAT = 3;
    localparam int PIN_ERR  = 4;
    localparam int PIN_TDI  = 5;
    localparam int PIN_TDO  = 6;
    localparam int MIN_PORT_W = 7;

    typedef enum logic [1:0] {
        ROLE_GPIO  = 2'd0,
        ROLE_TAPIN = 2'd1,
        ROLE_TDO   = 2'd2,
        ROLE_EXT   = 2'd3
    } pin_role_t;

    // Map a pin index to the role it takes when the channel owns the port
    function automatic pin_role_t role_of(input int idx);
        pin_role_t r;
        if (idx == PIN_TMS || idx == PIN_TCK || idx == PIN_TDI)
            r = ROLE_TAPIN;
        else if (idx == PIN_TDO)
            r = ROLE_TDO;
        else if (idx == PIN_STAT || idx == PIN_ERR)
            r = ROLE_EXT;
        else
            r = ROLE_GPIO;
        return r;
    endfunction

endpackage

// File: rtl/jps_enable_reg.sv
`timescale 1ns/1ps
// Module: run-time enable register.
// Holds one enable bit that is written at a fixed offset and cleared by reset.
// The read path is combinational: the bit appears in bit 0 at the offset,
// and every other address reads zero.
module jps_enable_reg #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int EN_OFFSET = 'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run_en
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = EN_OFFSET[ADDR_W-1:0];

    logic en_q;
    logic hit;
    logic unused_wdata;

    assign hit          = (bus_addr == HIT_ADDR);
    assign unused_wdata = ^bus_wdata[DATA_W-1:1];

    // Update the enable bit on reset or on a write that hits the offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (bus_we && hit)
            en_q <= bus_wdata[0];
    end

    // Return the bit at the offset, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (hit)
            bus_rdata[0] = en_q;
    end

    assign run_en = en_q;

endmodule

// File: rtl/jps_owner.sv
`timescale 1ns/1ps
// Module: ownership and activation tracker.
// ORs the three enable sources and applies the reset rule: the nonvolatile
// source is immune to reset, the others are blocked by it. It also holds the
// data-out drive flag and the extension flag that an accepted enabling
// command sets. It assumes cmd_pulse is high for one cycle at a time.
module jps_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_cfg,
    input  logic run_en,
    input  logic pt_select,
    input  logic cmd_pulse,
    input  logic cmd_ext,
    output logic jtag_on,
    output logic tap_gate,
    output logic tdo_drive,
    output logic ext_drive
);
    logic tdo_q;
    logic ext_q;
    logic wipe;

    assign jtag_on  = nv_cfg | run_en | pt_select;
    assign tap_gate = jtag_on & (nv_cfg | rst_n);
    // Flags drop when ownership ends, or on reset unless nonvolatile-held
    assign wipe     = !jtag_on || (!rst_n && !nv_cfg);

    // Track the activation flags
    always_ff @(posedge clk) begin
        if (wipe) begin
            tdo_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (cmd_pulse && tap_gate) begin
            tdo_q <= 1'b1;
            ext_q <= cmd_ext;
        end
    end

    assign tdo_drive = tdo_q;
    assign ext_drive = ext_q;

endmodule

// File: rtl/jps_pin_mux.sv
`timescale 1ns/1ps
// Module: one pad's mux between the GPIO side and the JTAG channel.
// ROLE picks the variant. TAP inputs become undriven inputs, the data-out pin
// drives only when activated, and extension pins drive only when their flag
// is set. Pins held by the channel return zero to the GPIO side.
module jps_pin_mux #(
    parameter jps_pkg::pin_role_t ROLE = jps_pkg::ROLE_GPIO
) (
    input  logic jtag_on,
    input  logic tdo_drive,
    input  logic ext_drive,
    input  logic jtag_val,
    input  logic gpio_out_i,
    input  logic gpio_oe_i,
    input  logic pad_in_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic gpio_in_o
);
    logic take;

    // Decide whether the channel holds this pad
    always_comb begin
        case (ROLE)
            jps_pkg::ROLE_TAPIN: take = jtag_on;
            jps_pkg::ROLE_TDO:   take = jtag_on;
            jps_pkg::ROLE_EXT:   take = jtag_on & ext_drive;
            default:             take = 1'b0;
        endcase
    end

    // Select pad drive from the owner
    always_comb begin
        if (!take) begin
            pad_out_o = gpio_out_i;
            pad_oe_o  = gpio_oe_i;
        end else begin
            case (ROLE)
                jps_pkg::ROLE_TDO: begin
                    pad_oe_o  = tdo_drive;
                    pad_out_o = tdo_drive & jtag_val;
                end
                jps_pkg::ROLE_EXT: begin
                    pad_oe_o  = 1'b1;
                    pad_out_o = jtag_val;
                end
                default: begin
                    pad_oe_o  = 1'b0;
                    pad_out_o = 1'b0;
                end
            endcase
        end
    end

    assign gpio_in_o = take ? 1'b0 : pad_in_i;

endmodule

// File: rtl/jtag_port_share.sv
`timescale 1ns/1ps
// Module: top of the JTAG pin-sharing port controller.
// Combines the enable register, the ownership tracker and one pin mux per
// port bit. Assumes PORT_W >= 7 so that the fixed pin positions exist.
module jtag_port_share #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PORT_W    = 8,
    parameter int EN_OFFSET = 'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_cfg_jtag,
    input  logic              pt_select,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmd_pulse,
    input  logic              cmd_ext,
    input  logic              tap_tdo,
    input  logic              tap_tstat,
    input  logic              tap_terr,
    output logic              tap_tms,
    output logic              tap_tck,
    output logic              tap_tdi,
    output logic              tap_enable,
    output logic              jtag_owned,
    input  logic [PORT_W-1:0] gpio_out,
    input  logic [PORT_W-1:0] gpio_oe,
    output logic [PORT_W-1:0] gpio_in,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    import jps_pkg::*;

    logic run_en;
    logic jtag_on;
    logic tap_gate;
    logic tdo_drive;
    logic ext_drive;

    jps_enable_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .EN_OFFSET (EN_OFFSET)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .run_en    (run_en)
    );

    jps_owner u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_cfg    (nv_cfg_jtag),
        .run_en    (run_en),
        .pt_select (pt_select),
        .cmd_pulse (cmd_pulse),
        .cmd_ext   (cmd_ext),
        .jtag_on   (jtag_on),
        .tap_gate  (tap_gate),
        .tdo_drive (tdo_drive),
        .ext_drive (ext_drive)
    );

    // One mux per port bit, variant chosen by the bit's role
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        localparam pin_role_t R = role_of(i);
        logic jv;
        if (i == PIN_TDO) begin : g_tdo
            assign jv = tap_tdo;
        end else if (i == PIN_STAT) begin : g_stat
            assign jv = tap_tstat;
        end else if (i == PIN_ERR) begin : g_err
            assign jv = tap_terr;
        end else begin : g_none
            assign jv = 1'b0;
        end
        jps_pin_mux #(.ROLE(R)) u_mux (
            .jtag_on    (jtag_on),
            .tdo_drive  (tdo_drive),
            .ext_drive  (ext_drive),
            .jtag_val   (jv),
            .gpio_out_i (gpio_out[i]),
            .gpio_oe_i  (gpio_oe[i]),
            .pad_in_i   (pad_in[i]),
            .pad_out_o  (pad_out[i]),
            .pad_oe_o   (pad_oe[i]),
            .gpio_in_o  (gpio_in[i])
        );
    end

    // Forward TAP inputs; idle values keep the TAP parked when gated
    always_comb begin
        if (tap_gate) begin
            tap_tms = pad_in[PIN_TMS];
            tap_tck = pad_in[PIN_TCK];
            tap_tdi = pad_in[PIN_TDI];
        end else begin
            tap_tms = 1'b1;
            tap_tck = 1'b0;
            tap_tdi = 1'b0;
        end
    end

    assign tap_enable = tap_gate;
    assign jtag_owned = jtag_on;

endmodule

// File: rtl/jps_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for jtag_port_share, attached with bind.
// Assumes cmd_pulse is a single-cycle pulse and PORT_W >= 7.
module jps_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_cfg_jtag,
    input logic              pt_select,
    input logic              cmd_pulse,
    input logic              tap_tdo,
    input logic              tap_tck,
    input logic              tap_tms,
    input logic              tap_enable,
    input logic              jtag_owned,
    input logic [PORT_W-1:0] gpio_out,
    input logic [PORT_W-1:0] gpio_oe,
    input logic [PORT_W-1:0] gpio_in,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe
);
    import jps_pkg::*;

    // R1: either external source alone takes the mode-select pad off the GPIO side
    assert_ext_src_owns_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_cfg_jtag || pt_select) |-> (jtag_owned && !pad_oe[PIN_TMS]));

    // R3: after reset with no external source the port is plain GPIO
    assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !nv_cfg_jtag && !pt_select) |-> (pad_oe == gpio_oe));

    // R4: TAP input pads are never driven while owned
    assert_tapin_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_owned |-> (!pad_oe[PIN_TCK] && !pad_oe[PIN_TDI] && gpio_in[PIN_TMS] == 1'b0));

    // R5: an accepted command drives data out on the next cycle
    assert_cmd_drives_tdo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && tap_enable) |=> (!jtag_owned || (pad_oe[PIN_TDO] && pad_out[PIN_TDO] == tap_tdo)));

    // R7: unowned port passes GPIO straight through
    assert_gpio_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !jtag_owned |-> (pad_oe == gpio_oe && pad_out == gpio_out && gpio_in == pad_in));

    // R7: data-out pad cannot be driven by the channel right after ownership ends
    assert_tdo_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!jtag_owned) && jtag_owned) |-> !pad_oe[PIN_TDO]);

    // R8 / R9: reset rule on the TAP clock path
    always @(posedge clk) begin
        if (!rst_n && nv_cfg_jtag)
            assert_nv_survives_R8: assert (tap_enable && tap_tck == pad_in[PIN_TCK]);
        if (!rst_n && !nv_cfg_jtag)
            assert_reset_blocks_R9: assert (!tap_enable && !tap_tck && tap_tms);
    end

endmodule

bind jtag_port_share jps_chk #(.PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_cfg_jtag (nv_cfg_jtag),
    .pt_select   (pt_select),
    .cmd_pulse   (cmd_pulse),
    .tap_tdo     (tap_tdo),
    .tap_tck     (tap_tck),
    .tap_tms     (tap_tms),
    .tap_enable  (tap_enable),
    .jtag_owned  (jtag_owned),
    .gpio_out    (gpio_out),
    .gpio_oe     (gpio_oe),
    .gpio_in     (gpio_in),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
);

// File: tb/sim_jtag_port_share.sv
`timescale 1ns/1ps
// Bench: seeded random traffic plus directed corners, checked against a
// model built from the requirements.
module sim_jtag_port_share;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PW = 8;
    localparam logic [AW-1:0] EN_ADDR = 8'hC7;

    logic clk = 1'b0;
    logic rst_n, nv, pt, we, cmd, cext, tdo, tstat, terr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic tms_o, tck_o, tdi_o, ten_o, own_o;
    logic [PW-1:0] gout, goe, gin, pin, pout, poe;

    always #10 clk = ~clk;

    jtag_port_share u0 (
        .clk(clk), .rst_n(rst_n), .nv_cfg_jtag(nv), .pt_select(pt),
        .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .cmd_pulse(cmd), .cmd_ext(cext), .tap_tdo(tdo), .tap_tstat(tstat),
        .tap_terr(terr), .tap_tms(tms_o), .tap_tck(tck_o), .tap_tdi(tdi_o),
        .tap_enable(ten_o), .jtag_owned(own_o), .gpio_out(gout), .gpio_oe(goe),
        .gpio_in(gin), .pad_in(pin), .pad_out(pout), .pad_oe(poe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic m_en = 1'b0, m_tdo = 1'b0, m_ext = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_on();
        return nv | m_en | pt;
    endfunction

    function automatic logic m_gate();
        return m_on() & (nv | rst_n);
    endfunction

    // Check all outputs against the model for the current inputs
    task automatic check_all();
        logic [PW-1:0] eo, eoe, egi;
        eo = gout; eoe = goe; egi = pin;
        if (m_on()) begin
            for (int i = 0; i < PW; i++) begin
                if (i == 0 || i == 1 || i == 5) begin
                    eo[i] = 1'b0; eoe[i] = 1'b0; egi[i] = 1'b0;
                end else if (i == 6) begin
                    eoe[i] = m_tdo; eo[i] = m_tdo & tdo; egi[i] = 1'b0;
                end else if ((i == 3 || i == 4) && m_ext) begin
                    eoe[i] = 1'b1; eo[i] = (i == 3) ? tstat : terr; egi[i] = 1'b0;
                end
            end
        end
        chk(m_on() ? (m_tdo ? "R5 pad_oe" : "R4 pad_oe") : "R7 pad_oe", poe, eoe);
        chk(m_ext ? "R6 pad_out" : "R7 pad_out", pout, eo);
        chk("R4 gpio_in", gin, egi);
        chk("R1 jtag_owned", own_o, m_on());
        chk(rst_n ? "R10 tap_enable" : (nv ? "R8 tap_enable" : "R9 tap_enable"), ten_o, m_gate());
        chk("R10 tap pins", {tms_o, tck_o, tdi_o},
            m_gate() ? {pin[0], pin[1], pin[5]} : 3'b100);
        chk("R2 rdata", rdata, (addr == EN_ADDR) ? {7'd0, m_en} : 8'd0);
    endtask

    // One cycle: check, clock, update model, return at falling edge
    task automatic step();
        logic on_old, gate_old;
        #1;
        check_all();
        @(posedge clk);
        on_old = m_on();
        gate_old = m_gate();
        if (!on_old || (!rst_n && !nv)) begin
            m_tdo = 1'b0; m_ext = 1'b0;
        end else if (cmd && gate_old) begin
            m_tdo = 1'b1; m_ext = cext;
        end
        if (!rst_n) m_en = 1'b0;
        else if (we && addr == EN_ADDR) m_en = wdata[0];
        @(negedge clk);
    endtask

    task automatic idle();
        we = 1'b0; cmd = 1'b0; cext = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; nv = 1'b0; pt = 1'b0; addr = '0; wdata = '0;
        tdo = 1'b0; tstat = 1'b0; terr = 1'b0;
        gout = 8'hA5; goe = 8'h3C; pin = 8'h5A;
        idle();
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        // R3: reset state, enable bit reads zero, port plain GPIO
        addr = EN_ADDR; #1;
        chk("R3 reset enable bit", rdata, 8'h00);
        chk("R7 reset pad_oe", poe, goe);
        step();

        // R2: write other offset, then set bit at offset
        addr = 8'hC6; we = 1'b1; wdata = 8'hFF; step();
        idle(); addr = EN_ADDR; #1; chk("R2 other offset ignored", rdata, 8'h00);
        step();
        we = 1'b1; wdata = 8'h01; step();
        idle(); #1; chk("R2 bit set", rdata, 8'h01); chk("R1 reg source", own_o, 1'b1);
        // R4: TDO not driven before command
        chk("R4 tdo undriven", poe[6], 1'b0);
        step();
        // R5/R6: command with extension
        tdo = 1'b1; tstat = 1'b1; terr = 1'b0; cmd = 1'b1; cext = 1'b1; step();
        idle(); #1;
        chk("R5 tdo driven", {poe[6], pout[6]}, 2'b11);
        chk("R6 ext pins", {poe[4:3], pout[4:3]}, 4'b1101);
        step();
        // R9: reset with register-only enable blocks channel and clears flags
        rst_n = 1'b0; #1; chk("R9 gated", {ten_o, tck_o, tms_o}, 3'b001);
        step(); rst_n = 1'b1; pt = 1'b1; #1;
        chk("R9 flags cleared", poe[6], 1'b0);
        step();
        // R6: command without extension leaves status pins on GPIO
        cmd = 1'b1; cext = 1'b0; step(); idle(); #1;
        chk("R6 no ext", poe[4:3], goe[4:3]);
        step();
        // R8: nonvolatile hold survives reset
        pt = 1'b0; nv = 1'b1; cmd = 1'b1; cext = 1'b1; step(); idle();
        rst_n = 1'b0; pin = 8'h02; step(); step(); #1;
        chk("R8 flags kept", {ten_o, tck_o, poe[6]}, 3'b111);
        rst_n = 1'b1; nv = 1'b0; step();
        // R7: ownership off then back on: TDO quiet until new command
        pt = 1'b1; #1; chk("R7 flags cleared on drop", poe[6], 1'b0);
        step(); pt = 1'b0;

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic prev_cmd;
            prev_cmd = cmd;
            rst_n = ($urandom_range(0, 24) != 0);
            nv    = ($urandom_range(0, 5) == 0);
            pt    = ($urandom_range(0, 4) == 0);
            we    = ($urandom_range(0, 3) == 0);
            addr  = ($urandom_range(0, 1) == 0) ? EN_ADDR : 8'($urandom);
            wdata = 8'($urandom);
            cmd   = prev_cmd ? 1'b0 : ($urandom_range(0, 6) == 0);
            cext  = 1'($urandom);
            tdo   = 1'($urandom); tstat = 1'($urandom); terr = 1'($urandom);
            gout  = 8'($urandom); goe = 8'($urandom); pin = 8'($urandom);
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule